// File: doc/BRIEF.md
# Constant-Divisor Divider by Reciprocal Multiplication

This block divides an unsigned N-bit operand by a divisor fixed when the block is built, and returns the exact truncated integer quotient. No iterative divider is used. At elaboration, the parameters DIVISOR and N are reduced to a reciprocal constant and a right-shift amount. At run time one multiply and one shift produce the result.

The constant is chosen by a remainder test. Let L be the floor of log2(DIVISOR). The value 2^(N+L) is divided by DIVISOR, giving quotient m and remainder r.
- If twice r exceeds DIVISOR, m+1 is used with a shift of N+L.
- Otherwise the constant becomes 2m+1 with a shift of N+L+1.

The constant therefore never needs more than N+1 significant bits.

Two divisor classes skip the multiplier:
- A divisor of 1 passes the operand straight through.
- A power-of-two divisor uses a plain shift.

A divisor of zero, or one that does not fit in N bits, stops elaboration. An optional output register adds one cycle of latency. Without it, the quotient is combinational.

Top module: `cdiv_const`

## Requirements
- R1: For every N-bit value on in_data accepted with in_valid high, quotient equals floor(in_data / DIVISOR).
- R2: With DIVISOR = 1, quotient equals in_data bit for bit.
- R3: With DIVISOR = 2^k, quotient equals in_data shifted right by k bits (k = 4 for a divisor of 16).
- R4: Where the remainder test chooses the widened constant (2·r ≤ DIVISOR, e.g. divisor 7 at N = 8, divisor 1000 at N = 16), the quotient is exact for every input, including all-ones.
- R5: Where the remainder test chooses the rounded-up constant (2·r > DIVISOR, e.g. divisor 3 at N = 8, divisor 10 at N = 32), the quotient is exact for every input.
- R6: The following inputs give exact quotients: 0 gives 0; all-ones gives floor((2^N−1)/DIVISOR); every multiple of DIVISOR and its two neighbours give the exact quotient.
- R7: With OUT_REG = 1, out_valid at each rising edge takes the in_valid sampled at that edge. The quotient it flags belongs to the in_data of that same edge.
- R8: With OUT_REG = 0, out_valid equals in_valid in the same cycle, and quotient is valid combinationally.
- R9: With OUT_REG = 1, rst_n low clears out_valid and quotient to 0 at once, and holds them there while it stays low, whatever in_valid does.
- R10: With OUT_REG = 1, a rising edge with in_valid low leaves quotient unchanged, whatever in_data carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present on in_data |
| in_data | input | N | Unsigned dividend |
| out_valid | output | 1 | Quotient present on quotient |
| quotient | output | N | floor(in_data / DIVISOR) |

## Verification
Reset and a valid operand can fall in the same cycle. The bench provokes this by pulling rst_n low while in_valid is high with fresh data. It judges the outcome by requiring that out_valid and quotient read zero at once and stay zero, and that the first operand after release appears one edge later with its exact quotient.

An idle cycle and a changing in_data can also coincide. For this the bench drops in_valid while driving random data. It requires the registered quotient to keep the last accepted result while the unregistered instances still track the bus exactly.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  typedef enum logic [1:0] {
    CDIV_PASS  = 2'd0,
    CDIV_SHIFT = 2'd1,
    CDIV_MULT  = 2'd2
  } cdiv_mode_e;

  function automatic int unsigned floor_log2(input longint unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 64; i++) begin
      if ((v >> i) != 64'd0) r = i;
    end
    return r;
  endfunction

  function automatic bit is_pow2(input longint unsigned v);
    return (v != 64'd0) && ((v & (v - 64'd1)) == 64'd0);
  endfunction

  function automatic cdiv_mode_e pick_mode(input longint unsigned d);
    if (d == 64'd1) return CDIV_PASS;
    if (is_pow2(d)) return CDIV_SHIFT;
    return CDIV_MULT;
  endfunction

  // 2^(n + floor(log2 d)); n <= 32 keeps this inside 64 bits
  function automatic longint unsigned scaled_one(input int unsigned n, input longint unsigned d);
    return 64'd1 << (n + floor_log2(d));
  endfunction

  // true when the remainder is at most half the divisor
  function automatic bit needs_widen(input int unsigned n, input longint unsigned d);
    longint unsigned rem;
    rem = scaled_one(n, d) % d;
    return !((rem << 1) > d);
  endfunction

  function automatic longint unsigned recip_const(input int unsigned n, input longint unsigned d);
    longint unsigned m;
    if (pick_mode(d) != CDIV_MULT) return 64'd0;
    m = scaled_one(n, d) / d;
    if (needs_widen(n, d)) return (m << 1) | 64'd1;
    return m + 64'd1;
  endfunction

  function automatic int unsigned recip_shift(input int unsigned n, input longint unsigned d);
    if (pick_mode(d) == CDIV_PASS) return 0;
    if (pick_mode(d) == CDIV_SHIFT) return floor_log2(d);
    return n + floor_log2(d) + (needs_widen(n, d) ? 1 : 0);
  endfunction

endpackage

// File: rtl/cdiv_mul_shift.sv
module cdiv_mul_shift
  import cdiv_pkg::*;
#(
  parameter int unsigned N       = 8,
  parameter int unsigned DIVISOR = 7
) (
  input  logic [N-1:0] x,
  output logic [N-1:0] q
);

  localparam cdiv_mode_e MODE = pick_mode(64'(DIVISOR));

  generate
    if (MODE == CDIV_PASS) begin : g_pass
      assign q = x;
    end else if (MODE == CDIV_SHIFT) begin : g_shift
      localparam int unsigned SH = recip_shift(N, 64'(DIVISOR));
      assign q = x >> SH;
    end else begin : g_mult
      localparam int unsigned PW = 2 * N + 1;
      localparam int unsigned SH = recip_shift(N, 64'(DIVISOR));
      localparam logic [PW-1:0] RECIP = PW'(recip_const(N, 64'(DIVISOR)));
      logic [PW-1:0] prod;
      assign prod = PW'(x) * RECIP;
      assign q    = N'(prod >> SH);
    end
  endgenerate

endmodule

// File: rtl/cdiv_out_stage.sv
module cdiv_out_stage #(
  parameter int unsigned N       = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [N-1:0] q_in,
  output logic         v_out,
  output logic [N-1:0] q_out
);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_out <= 1'b0;
          q_out <= '0;
        end else begin
          v_out <= v_in;
          if (v_in) q_out <= q_in;
        end
      end
    end else begin : g_wire
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign v_out = v_in;
      assign q_out = q_in;
    end
  endgenerate

endmodule

// File: rtl/cdiv_const.sv
module cdiv_const
  import cdiv_pkg::*;
#(
  parameter int unsigned N       = 8,
  parameter int unsigned DIVISOR = 7,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] in_data,
  output logic         out_valid,
  output logic [N-1:0] quotient
);

  generate
    if (DIVISOR == 0 || N == 0 || N > 32 || 64'(DIVISOR) >= (64'd1 << N)) begin : g_bad_cfg
      $fatal(1, "cdiv_const: DIVISOR must be nonzero and fit in N bits, N in 1..32");
    end
  endgenerate

  // combinational quotient, brought out for the checker
  logic [N-1:0] core_q;

  cdiv_mul_shift #(
    .N       (N),
    .DIVISOR (DIVISOR)
  ) u_core (
    .x (in_data),
    .q (core_q)
  );

  cdiv_out_stage #(
    .N       (N),
    .OUT_REG (OUT_REG)
  ) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .v_in  (in_valid),
    .q_in  (core_q),
    .v_out (out_valid),
    .q_out (quotient)
  );

endmodule

// File: rtl/cdiv_const_chk.sv
module cdiv_const_chk #(
  parameter int unsigned N       = 8,
  parameter int unsigned DIVISOR = 7,
  parameter bit          OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [N-1:0] in_data,
  input logic         out_valid,
  input logic [N-1:0] quotient,
  input logic [N-1:0] core_q
);

  localparam logic [N-1:0] DV = N'(DIVISOR);

  AST_CORE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> core_q == in_data / DV); // R1

  AST_REMAINDER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_data - core_q * DV) < DV); // R4

  generate
    if (OUT_REG) begin : g_reg
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
      AST_BUBBLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
      AST_REG_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> quotient == $past(in_data) / DV); // R7
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(quotient)); // R10
      AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R9
    end else begin : g_comb
      AST_ZERO_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid); // R8
      AST_COMB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> quotient == in_data / DV); // R8
    end
  endgenerate

endmodule

bind cdiv_const cdiv_const_chk #(
  .N       (N),
  .DIVISOR (DIVISOR),
  .OUT_REG (OUT_REG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .quotient  (quotient),
  .core_q    (core_q)
);

// File: tb/sim_cdiv_const.sv
module sim_cdiv_const;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] din = '0;

  always #10 clk = ~clk;  // 50 MHz

  logic ov0, ov1, ov2, ov3, ov4, ov5;
  logic [7:0]  q0, q1, q2, q3;
  logic [15:0] q4;
  logic [31:0] q5;

  // widened constant, registered
  cdiv_const #(.N(8), .DIVISOR(7), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(din[7:0]), .out_valid(ov0), .quotient(q0));
  // rounded-up constant, registered
  cdiv_const #(.N(8), .DIVISOR(3), .OUT_REG(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(din[7:0]), .out_valid(ov1), .quotient(q1));
  // pass-through, combinational
  cdiv_const #(.N(8), .DIVISOR(1), .OUT_REG(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(din[7:0]), .out_valid(ov2), .quotient(q2));
  // power of two, registered
  cdiv_const #(.N(8), .DIVISOR(16), .OUT_REG(1'b1)) u3 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(din[7:0]), .out_valid(ov3), .quotient(q3));
  // widened constant, 16 bit, combinational
  cdiv_const #(.N(16), .DIVISOR(1000), .OUT_REG(1'b0)) u4 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(din[15:0]), .out_valid(ov4), .quotient(q4));
  // rounded-up constant, 32 bit, registered
  cdiv_const #(.N(32), .DIVISOR(10), .OUT_REG(1'b1)) u5 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_data(din), .out_valid(ov5), .quotient(q5));

  int n_run = 0;
  int n_fail = 0;
  logic        prev_vld = 1'b0;
  logic [31:0] prev_din = '0;

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: check registered results of the previous operand, drive the next,
  // then check the combinational instances in the same cycle
  task automatic step(input logic v, input logic [31:0] x);
    @(negedge clk);
    chk("R7", "u0 out_valid", ov0, prev_vld);
    chk("R7", "u5 out_valid", ov5, prev_vld);
    chk("R7", "u1 out_valid", ov1, prev_vld);
    if (prev_vld) begin
      chk("R1,R4", "u0 quotient", q0, prev_din[7:0] / 8'd7);
      chk("R5", "u1 quotient", q1, prev_din[7:0] / 8'd3);
      chk("R3", "u3 quotient", q3, prev_din[7:0] >> 4);
      chk("R5", "u5 quotient", q5, prev_din / 32'd10);
    end
    vld = v;
    din = x;
    #1;
    chk("R8", "u2 out_valid", ov2, v);
    chk("R8", "u4 out_valid", ov4, v);
    if (v) begin
      chk("R2", "u2 quotient", q2, x[7:0]);
      chk("R1,R4", "u4 quotient", q4, x[15:0] / 16'd1000);
    end
    prev_vld = v;
    prev_din = x;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R9", "u0 out_valid in reset", ov0, 0);
    chk("R9", "u0 quotient in reset", q0, 0);
    chk("R9", "u5 out_valid in reset", ov5, 0);
    chk("R9", "u5 quotient in reset", q5, 0);
    rst_n = 1'b1;
    prev_vld = 1'b0;
  endtask

  task automatic t_exhaustive8();
    for (int v = 0; v < 256; v++) step(1'b1, 32'(v) | 32'(v << 8));
    step(1'b0, 32'd0);
  endtask

  task automatic t_edges();
    logic [31:0] ev[$];
    logic [31:0] m;
    ev = '{32'd0, 32'd1, 32'd2, 32'd9, 32'd10, 32'd11, 32'd999, 32'd1000, 32'd1001,
           32'd64999, 32'd65000, 32'd65001, 32'd65535, 32'hFFFF_FFFE, 32'hFFFF_FFFF,
           32'd4294967289, 32'd4294967290, 32'd4294967291};
    foreach (ev[i]) step(1'b1, ev[i]);
    for (int k = 0; k < 16; k++) begin
      m = (32'd429496729 - 32'(k) * 32'd26843545) * 32'd10;
      step(1'b1, m - 32'd1);
      step(1'b1, m);
      step(1'b1, m + 32'd1);
    end
    for (int k = 1; k <= 65; k++) begin
      m = 32'(k) * 32'd1000;
      step(1'b1, m - 32'd1);
      step(1'b1, m);
      step(1'b1, m + 32'd1);
    end
    // explicit corner checks
    step(1'b1, 32'd0);
    chk("R6", "u4 zero", q4, 0);
    step(1'b1, 32'hFFFF_FFFF);
    chk("R6", "u0 zero", q0, 0);
    chk("R6", "u5 zero", q5, 0);
    chk("R6", "u4 all-ones", q4, 65);
    step(1'b0, 32'd0);
    chk("R6", "u0 all-ones", q0, 36);
    chk("R6", "u1 all-ones", q1, 85);
    chk("R6", "u5 all-ones", q5, 429496729);
  endtask

  task automatic t_random();
    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, $urandom);
    step(1'b0, 32'd0);
  endtask

  task automatic t_hold();
    step(1'b1, 32'd200);
    step(1'b0, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      din = $urandom;
      #1;
      chk("R10", "u0 held quotient", q0, 28);
      chk("R10", "u1 held quotient", q1, 66);
      chk("R10", "u5 held quotient", q5, 20);
      chk("R7", "u0 idle out_valid", ov0, 0);
      chk("R8", "u4 follows bus", q4, din[15:0] / 16'd1000);
    end
    prev_vld = 1'b0;
  endtask

  task automatic t_reset_mid();
    step(1'b1, 32'd77);
    step(1'b1, 32'd150);
    @(negedge clk);
    vld = 1'b1;
    din = 32'd99;
    rst_n = 1'b0;
    #1;
    chk("R9", "u0 out_valid cleared at once", ov0, 0);
    chk("R9", "u0 quotient cleared at once", q0, 0);
    chk("R9", "u5 quotient cleared at once", q5, 0);
    @(negedge clk);
    chk("R9", "u0 out_valid held in reset", ov0, 0);
    chk("R9", "u3 quotient held in reset", q3, 0);
    rst_n = 1'b1;
    prev_vld = 1'b1;
    prev_din = 32'd99;
    step(1'b1, 32'd140);
    step(1'b0, 32'd0);
    step(1'b0, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_exhaustive8();
    t_edges();
    t_hold();
    t_reset_mid();
    t_random();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule